// File: doc/BRIEF.md
# DMA Register Front End with Interrupt Aggregation

This unit is the software-visible register side of a multi-channel DMA controller. Each channel owns a memory-address word, a block-control word and a channel-control word. Two shared words complete the map: a primary control word that carries a per-channel run-enable bit, and an interrupt control word that aggregates channel completions into one request toward the system interrupt controller. The transfer engines sit outside this unit. They receive a one-cycle start pulse per channel and report back with a one-cycle completion pulse.

A write to a channel-control word launches that channel only if both the written value and the primary control word allow it. The interrupt control word mixes three kinds of bits: plain read/write fields, write-one-to-clear completion flags, and an internally kept "request already sent" bit. Because of that bit, the interrupt controller sees one pulse per rise of the interrupt condition and not one per event.

Top module: `dma_reg_unit`

## Requirements
- R1: After reset every mapped word reads 0, and no start pulse or interrupt pulse is produced.
- R2: Channel n occupies byte offsets 0x080+0x10*n: address word at +0x0, block word at +0x4, control word at +0x8. The primary control word is at 0x0F0 and the interrupt control word at 0x0F4. The address, block, control and primary words read back the last value written. Any other offset reads 0.
- R3: `ch_start[n]` is high for exactly the one cycle after a write to channel n's control word. It rises only when the written bit 24 is 1 and bit 4*n+3 of the primary control word is 1.
- R4: Bit 24 of channel n's control word holds its written value until `ch_done[n]` pulses, and reads 0 from the next cycle on (a write in the same cycle wins).
- R5: A write to the interrupt control word loads the bits selected by mask 0x00FF803F directly. Bits 6..14 always read 0.
- R6: Completion flags sit in bits 24..30. A written 1 clears the flag. A written 0 leaves it unchanged.
- R7: `ch_done[n]` sets flag bit 24+n only when enable bit 16+n of the interrupt control word is 1.
- R8: A `bus_err` pulse sets bit 15 of the interrupt control word.
- R9: The interrupt condition is (bit 23 AND any of bits 24..30) OR bit 15, evaluated after each update. Bit 31 reads as the condition and drops to 0 when the condition is false.
- R10: `irq_pulse` is high for one cycle when the condition holds while bit 31 was 0 before the update. No further pulse comes while the condition stays true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| ch_done | input | NUM_CH | Per-channel completion pulse from the transfer engines |
| bus_err | input | 1 | Bus-error pulse from the transfer engines |
| ch_start | output | NUM_CH | Per-channel start pulse toward the transfer engines |
| irq_pulse | output | 1 | One-cycle request toward the interrupt controller |

## Verification
The hardest state to reach is a renewed interrupt edge that comes from no new event. The bench first collects a flag while the global enable is off, so no request goes out. A later write then sets only the global enable, and the condition rises with the sent bit clear, so a pulse must appear. The bench also checks that a second completion, and a partial flag clear that leaves another flag standing, produce no pulse. The reference model in the bench compares both pulse outputs on every clock, which catches any pulse that is late, repeated or missing.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   localparam int WORD_W = 32;

   localparam logic [11:0] CH_BASE_OFF = 12'h080;
   localparam logic [11:0] PRI_OFF     = 12'h0F0;
   localparam logic [11:0] IRQ_OFF     = 12'h0F4;

   localparam int START_BIT  = 24;
   localparam int FLAG_LSB   = 24;
   localparam int FLAG_CNT   = 7;
   localparam int EN_LSB     = 16;
   localparam int GLOBAL_BIT = 23;
   localparam int BERR_BIT   = 15;
   localparam int SENT_BIT   = 31;

   localparam logic [WORD_W-1:0] IRQ_RW_MASK   = 32'h00FF_803F;
   localparam logic [WORD_W-1:0] IRQ_FLAG_MASK = 32'h7F00_0000;

   typedef enum logic [1:0] {
      SEL_ADDR  = 2'd0,
      SEL_BLOCK = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_NONE  = 2'd3
   } chan_sel_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_regs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  chan_sel_e         wr_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              run_en,
   input  logic              done,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] block_q,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              start_q
);
   logic wr_ctrl;
   logic launch;

   assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
   assign launch  = wr_ctrl && wdata[START_BIT] && run_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         block_q <= '0;
         ctrl_q  <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= launch;
         if (wr_en && wr_sel == SEL_ADDR)  addr_q  <= wdata;
         if (wr_en && wr_sel == SEL_BLOCK) block_q <= wdata;
         if (wr_ctrl)   ctrl_q            <= wdata;
         else if (done) ctrl_q[START_BIT] <= 1'b0;
      end
   end

   // R3: an allowed launch gives a pulse one cycle later
   a_r3_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[START_BIT] && run_en) |=> start_q);
   // R3: no pulse without an allowed launch
   a_r3_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ctrl && wdata[START_BIT] && run_en) |=> !start_q);
   // R3: pulse lasts a single cycle unless relaunched
   a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && !wr_ctrl) |=> !start_q);
   // R4: completion clears the busy bit
   a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wr_ctrl) |=> !ctrl_q[START_BIT]);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
   import dma_regs_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NUM_CH-1:0] done,
   input  logic              bus_err,
   output logic [DATA_W-1:0] icr_q,
   output logic              irq_q
);
   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] icr_d;
   logic              cond;
   logic              any_flag;

   always_comb begin
      if (wr_en)
         base = (wdata & IRQ_RW_MASK) | (icr_q & ~wdata & IRQ_FLAG_MASK);
      else
         base = icr_q & ~(DATA_W'(1) << SENT_BIT);
      for (int n = 0; n < NUM_CH; n++) begin
         if (done[n] && base[EN_LSB+n]) base[FLAG_LSB+n] = 1'b1;
      end
      if (bus_err) base[BERR_BIT] = 1'b1;
      any_flag = |base[FLAG_LSB +: FLAG_CNT];
      cond     = (base[GLOBAL_BIT] && any_flag) || base[BERR_BIT];
      icr_d    = base;
      icr_d[SENT_BIT] = cond;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         icr_q <= '0;
         irq_q <= 1'b0;
      end else begin
         icr_q <= icr_d;
         irq_q <= cond && !icr_q[SENT_BIT];
      end
   end

   // R10: one pulse per rise of the condition
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);
   // R9: a pulse always comes with the sent bit set
   a_r9_sent_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> icr_q[SENT_BIT]);
   // R6: a written one clears its flag when no completion collides
   a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (done == '0)) |=>
         ((icr_q[FLAG_LSB +: FLAG_CNT] & $past(wdata[FLAG_LSB +: FLAG_CNT])) == '0));
   // R8: bus error is latched
   a_r8_berr: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> icr_q[BERR_BIT]);
   // R5: unused low bits never set
   a_r5_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      icr_q[14:6] == '0);
endmodule

// File: rtl/dma_reg_unit.sv
module dma_reg_unit
   import dma_regs_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] ch_done,
   input  logic              bus_err,
   output logic [NUM_CH-1:0] ch_start,
   output logic              irq_pulse
);
   localparam int SLOT_LO = int'(CH_BASE_OFF[7:4]);

   if (NUM_CH < 1 || NUM_CH > FLAG_CNT) begin : g_bad_ch
      $error("dma_reg_unit: NUM_CH must lie in 1..7");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("dma_reg_unit: ADDR_W must be at least 8");
   end
   if (DATA_W != WORD_W) begin : g_bad_data
      $error("dma_reg_unit: DATA_W must be 32");
   end

   logic hi_zero;
   if (ADDR_W > 8) begin : g_hi_chk
      assign hi_zero = ~|bus_addr[ADDR_W-1:8];
   end else begin : g_hi_none
      assign hi_zero = 1'b1;
   end

   logic [7:0]        low_addr;
   logic              hit_pri;
   logic              hit_irq;
   chan_sel_e         sel;
   logic [DATA_W-1:0] pri_q;
   logic [DATA_W-1:0] icr_q;

   assign low_addr = bus_addr[7:0];
   assign hit_pri  = hi_zero && (low_addr == PRI_OFF[7:0]);
   assign hit_irq  = hi_zero && (low_addr == IRQ_OFF[7:0]);

   always_comb begin
      case (low_addr[3:0])
         4'h0:    sel = SEL_ADDR;
         4'h4:    sel = SEL_BLOCK;
         4'h8:    sel = SEL_CTRL;
         default: sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                pri_q <= '0;
      else if (bus_wr && hit_pri) pri_q <= bus_wdata;
   end

   logic [DATA_W-1:0] ch_addr  [NUM_CH];
   logic [DATA_W-1:0] ch_block [NUM_CH];
   logic [DATA_W-1:0] ch_ctrl  [NUM_CH];
   logic [NUM_CH-1:0] ch_hit;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      assign ch_hit[n] = hi_zero && (low_addr[7:4] == 4'(SLOT_LO + n));
      dma_chan_regs #(.DATA_W(DATA_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_wr && ch_hit[n]),
         .wr_sel  (sel),
         .wdata   (bus_wdata),
         .run_en  (pri_q[4*n+3]),
         .done    (ch_done[n]),
         .addr_q  (ch_addr[n]),
         .block_q (ch_block[n]),
         .ctrl_q  (ch_ctrl[n]),
         .start_q (ch_start[n])
      );
   end

   dma_irq_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && hit_irq),
      .wdata   (bus_wdata),
      .done    (ch_done),
      .bus_err (bus_err),
      .icr_q   (icr_q),
      .irq_q   (irq_pulse)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit_pri) bus_rdata = pri_q;
      if (hit_irq) bus_rdata = icr_q;
      for (int n = 0; n < NUM_CH; n++) begin
         if (ch_hit[n]) begin
            case (sel)
               SEL_ADDR:  bus_rdata = ch_addr[n];
               SEL_BLOCK: bus_rdata = ch_block[n];
               SEL_CTRL:  bus_rdata = ch_ctrl[n];
               default:   bus_rdata = '0;
            endcase
         end
      end
   end

   // R2: primary control word captures the written value
   a_r2_pri_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_pri) |=> (pri_q == $past(bus_wdata)));
   // R1: no activity in the first cycle after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (ch_start == '0 && !irq_pulse));
endmodule

// File: tb/dma_reg_unit_bench.sv
module dma_reg_unit_bench;
   localparam int NCH = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] ch_done = '0;
   logic        bus_err = 1'b0;
   logic [NCH-1:0] ch_start;
   logic        irq_pulse;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   dma_reg_unit u_dma_reg_unit (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_done(ch_done),
      .bus_err(bus_err), .ch_start(ch_start), .irq_pulse(irq_pulse)
   );

   // behavioural reference for the pulse outputs
   logic [31:0]    m_pri;
   logic [31:0]    m_icr;
   logic [NCH-1:0] e_start;
   logic           e_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pri = 0; m_icr = 0; e_start = 0; e_irq = 0;
      end else begin
         logic [31:0] t;
         logic        c;
         int          slot;
         e_start = 0;
         slot = (int'(bus_addr) - 'h80) / 16;
         if (bus_wr && bus_addr >= 12'h080 && bus_addr < 12'h0F0 && bus_addr[3:0] == 4'h8)
            if (bus_wdata[24] && m_pri[4*slot+3]) e_start[slot] = 1'b1;
         if (bus_wr && bus_addr == 12'h0F4) begin
            t = bus_wdata & 32'h00FF803F;
            for (int b = 24; b <= 30; b++)
               if (m_icr[b] && !bus_wdata[b]) t[b] = 1'b1;
         end else begin
            t = m_icr;
            t[31] = 1'b0;
         end
         for (int k = 0; k < NCH; k++)
            if (ch_done[k] && t[16+k]) t[24+k] = 1'b1;
         if (bus_err) t[15] = 1'b1;
         c = (t[23] && (t[30:24] != 0)) || t[15];
         e_irq = c && !m_icr[31];
         t[31] = c;
         m_icr = t;
         if (bus_wr && bus_addr == 12'h0F0) m_pri = bus_wdata;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (ch_start !== e_start) begin
            failures++;
            $display("FAIL R3 ch_start actual=%b expected=%b", ch_start, e_start);
         end
         checks++;
         if (irq_pulse !== e_irq) begin
            failures++;
            $display("FAIL R10 irq_pulse actual=%b expected=%b", irq_pulse, e_irq);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic done_pulse(input int n);
      @(negedge clk);
      ch_done[n] = 1'b1;
      @(negedge clk);
      ch_done = '0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #2;
      checks++;
      if (bus_rdata !== exp) begin
         failures++;
         $display("FAIL %s read %h actual=%h expected=%h", req, a, bus_rdata, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(12'h080, 32'h0, "R1");
      rd(12'h0F0, 32'h0, "R1");
      rd(12'h0F4, 32'h0, "R1");
      rd(12'h0E8, 32'h0, "R1");
      // R2 readback and unmapped
      wr(12'h080, 32'h1234_5678);
      wr(12'h0A4, 32'hCAFE_0001);
      wr(12'h0F0, 32'h0000_0808);
      rd(12'h080, 32'h1234_5678, "R2");
      rd(12'h0A4, 32'hCAFE_0001, "R2");
      rd(12'h0F0, 32'h0000_0808, "R2");
      rd(12'h08C, 32'h0, "R2");
      rd(12'h0FC, 32'h0, "R2");
      rd(12'h180, 32'h0, "R2");
      // R3 launch enabled on ch0, refused on ch1
      wr(12'h088, 32'h0100_0000);
      wr(12'h098, 32'h0100_0000);
      rd(12'h098, 32'h0100_0000, "R3");
      wr(12'h0A8, 32'h0000_0001);
      // R4 completion clears busy bit; R7 no flag without enable
      rd(12'h088, 32'h0100_0000, "R4");
      done_pulse(0);
      rd(12'h088, 32'h0, "R4");
      rd(12'h0F4, 32'h0, "R7");
      // R5 / R9 / R10 masked write, bus-error bit drives condition
      wr(12'h0F4, 32'hFFFF_FFFF);
      rd(12'h0F4, 32'h80FF_803F, "R5");
      wr(12'h0F4, 32'h0000_0000);
      rd(12'h0F4, 32'h0, "R9");
      // R7 enable-gated flags
      wr(12'h0F4, 32'h0085_0000);
      done_pulse(1);
      rd(12'h0F4, 32'h0085_0000, "R7");
      done_pulse(2);
      rd(12'h0F4, 32'h8485_0000, "R7");
      done_pulse(0);
      rd(12'h0F4, 32'h8585_0000, "R10");
      // R6 write-one-to-clear
      wr(12'h0F4, 32'h0485_0000);
      rd(12'h0F4, 32'h8185_0000, "R6");
      wr(12'h0F4, 32'h0185_0000);
      rd(12'h0F4, 32'h0085_0000, "R9");
      // R8 bus error
      @(negedge clk); bus_err = 1'b1;
      @(negedge clk); bus_err = 1'b0;
      rd(12'h0F4, 32'h8085_8000, "R8");
      // R9 global enable off, then renewed edge by enabling it
      wr(12'h0F4, 32'h0005_0000);
      rd(12'h0F4, 32'h0005_0000, "R9");
      done_pulse(0);
      rd(12'h0F4, 32'h0105_0000, "R9");
      wr(12'h0F4, 32'h0085_0000);
      rd(12'h0F4, 32'h8185_0000, "R10");
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule